// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This unit watches the per-read result of an ECC checker on a 64-bit DRAM data path with 8 check bits. Each read may report a correctable (single-bit) error, an uncorrectable (multi-bit) error, or both. With each report come the address that failed, the data that was read and the check value. The unit keeps sticky flags for each error class. It freezes the details of the first error until software clears the flags. A correctable error raises its flag only after a programmable number of such errors has been counted. A level interrupt is driven from the flags, and each class has its own enable.

Software uses the unit through a plain 32-bit register port. Writes are single-cycle strobes. Reads are combinational from the word index. The unit also holds error-injection masks. When injection is armed, these masks are XORed into the memory write stream, which passes through as valid/ready. That stream adds no storage: `wr_in_ready` follows `wr_out_ready`, `wr_out_valid` follows `wr_in_valid`, and a beat transfers on the cycle where both valid and ready are high. Back-pressure therefore reaches the source with no delay.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: An accepted multi-bit error sets flag bit 1 of the detect register (index 0), and an accepted correctable error that completes its threshold sets bit 0. The flags are sticky. Writing 1 to a flag bit clears it, writing 0 leaves it as it is, and writing 0xFFFFFFFF clears both.
- R3: An accepted error of either class loads the capture registers only when both detect flags are 0. The capture registers are: address low word (index 5), upper address bits zero-extended (index 6), data high word (index 7), data low word (index 8) and check value (index 9). While any flag is set, they keep the first error's values.
- R4: The threshold register (index 3) holds the threshold in bits [23:16]. Bits [7:0] read back the running correctable-error count. Each accepted correctable error increments the count. When the count reaches the threshold, flag bit 0 is set and the count returns to 0. A threshold of 0 acts as 1, as does the value 0x00010000.
- R5: In the disable register (index 1), bit 0 masks correctable errors and bit 1 masks multi-bit errors. A masked error sets no flag, does not change the count and does not load the capture registers. Writing 0 enables both classes.
- R6: `irq` is high exactly while a detect flag is set whose bit is also set in the interrupt-enable register (index 2), using the same bit positions as the flags.
- R7: The captured check value reads back as its low 8 bits when bit 0 of the configuration register (index 4) is 0, meaning a 64-bit bus. It reads back as its low 16 bits when that bit is 1, meaning a 32-bit bus.
- R8: The injection registers can be read and written: high-word data mask (index 10), low-word data mask (index 11), and control (index 12, bits [8:0]). While control bit 8 is set, the write data is XORed with {high mask, low mask} and the write check value is XORed with control bits [7:0]. While bit 8 is clear, both pass through unchanged.
- R9: The write stream adds no latency and no storage. `wr_out_valid` equals `wr_in_valid` and `wr_in_ready` equals `wr_out_ready` in every cycle.
- R10: If a flag is set by an error in the same cycle that software writes 1 to clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ev_valid | input | 1 | Checker report valid this cycle |
| ev_sbe | input | 1 | Correctable error reported |
| ev_mbe | input | 1 | Uncorrectable error reported |
| ev_addr | input | ADDR_W | Failing address |
| ev_data | input | DATA_W | Data as read |
| ev_syn | input | SYN_W | Check value as read |
| wr_in_valid | input | 1 | Write stream input valid |
| wr_in_ready | output | 1 | Write stream input ready |
| wr_in_data | input | DATA_W | Write data in |
| wr_in_ecc | input | ECC_W | Generated check value in |
| wr_out_valid | output | 1 | Write stream output valid |
| wr_out_ready | input | 1 | Write stream output ready |
| wr_out_data | output | DATA_W | Write data after injection |
| wr_out_ecc | output | ECC_W | Check value after injection |
| irq | output | 1 | Level interrupt |

## Verification
A wrong flag value shows up on `irq` in the cycle after the report, provided the class is enabled. A flag that is set wrongly also freezes the capture registers, so the next error is not loaded and a register read shows the stale values. A counter that is off by one sets flag bit 0 one report too early or too late, and the count field shows the difference as soon as it is read. An injection fault shows up on the write stream in the same cycle, with no register in between.

// File: rtl/ecc_cap_pkg.sv
`timescale 1ns/1ps
package ecc_cap_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 4;
  localparam int FLG_W = 2;
  localparam int FLG_SBE = 0;
  localparam int FLG_MBE = 1;
  localparam int THR_LSB = 16;
  localparam int INJ_EN_BIT = 8;

  typedef enum logic [IDX_W-1:0] {
    RI_DETECT   = 4'd0,
    RI_DISABLE  = 4'd1,
    RI_INT_EN   = 4'd2,
    RI_SBE_CTL  = 4'd3,
    RI_CFG      = 4'd4,
    RI_CAP_ALO  = 4'd5,
    RI_CAP_AHI  = 4'd6,
    RI_CAP_DHI  = 4'd7,
    RI_CAP_DLO  = 4'd8,
    RI_CAP_SYN  = 4'd9,
    RI_INJ_HI   = 4'd10,
    RI_INJ_LO   = 4'd11,
    RI_INJ_CTL  = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/ecc_sbe_counter.sv
`timescale 1ns/1ps
module ecc_sbe_counter #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [THR_W-1:0] thr,
  output logic             fire,
  output logic [THR_W-1:0] count
);
  localparam int EXT_W = THR_W + 1;

  logic [EXT_W-1:0] next_cnt;
  logic [EXT_W-1:0] eff_thr;

  always_comb begin
    next_cnt = {1'b0, count} + EXT_W'(1);
    eff_thr  = (thr == '0) ? EXT_W'(1) : {1'b0, thr};
    fire     = hit && (next_cnt >= eff_thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (fire) count <= '0;
    else if (hit)  count <= next_cnt[THR_W-1:0];
  end
endmodule

// File: rtl/ecc_capture_bank.sv
`timescale 1ns/1ps
module ecc_capture_bank #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [SYN_W-1:0]  in_syn,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [SYN_W-1:0]  cap_syn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_data <= '0;
      cap_syn  <= '0;
    end else if (load) begin
      cap_addr <= in_addr;
      cap_data <= in_data;
      cap_syn  <= in_syn;
    end
  end
endmodule

// File: rtl/ecc_inject_xor.sv
`timescale 1ns/1ps
module ecc_inject_xor #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              enable,
  input  logic [DATA_W-1:0] data_mask,
  input  logic [ECC_W-1:0]  ecc_mask,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ECC_W-1:0]  in_ecc,
  output logic [DATA_W-1:0] out_data,
  output logic [ECC_W-1:0]  out_ecc
);
  localparam int NWORD = DATA_W / WORD_W;

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign out_data[w*WORD_W +: WORD_W] =
      in_data[w*WORD_W +: WORD_W] ^ (enable ? data_mask[w*WORD_W +: WORD_W] : '0);
  end

  assign out_ecc = in_ecc ^ (enable ? ecc_mask : '0);
endmodule

// File: rtl/ecc_err_capture.sv
`timescale 1ns/1ps
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int SYN_W  = 16,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ev_valid,
  input  logic              ev_sbe,
  input  logic              ev_mbe,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [DATA_W-1:0] ev_data,
  input  logic [SYN_W-1:0]  ev_syn,
  input  logic              wr_in_valid,
  output logic              wr_in_ready,
  input  logic [DATA_W-1:0] wr_in_data,
  input  logic [ECC_W-1:0]  wr_in_ecc,
  output logic              wr_out_valid,
  input  logic              wr_out_ready,
  output logic [DATA_W-1:0] wr_out_data,
  output logic [ECC_W-1:0]  wr_out_ecc,
  output logic              irq
);
  localparam int CTL_W = ECC_W + 1;

  logic [FLG_W-1:0]  det_q, dis_q, ien_q;
  logic [THR_W-1:0]  thr_q;
  logic              narrow_q;
  logic [REG_W-1:0]  inj_hi_q, inj_lo_q;
  logic [CTL_W-1:0]  inj_ctl_q;

  logic              sbe_hit, mbe_hit, sbe_fire, cap_load;
  logic [THR_W-1:0]  sbe_cnt;
  logic [FLG_W-1:0]  flg_set, flg_clr;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;
  logic [SYN_W-1:0]  cap_syn;

  assign sbe_hit  = ev_valid && ev_sbe && !dis_q[FLG_SBE];
  assign mbe_hit  = ev_valid && ev_mbe && !dis_q[FLG_MBE];
  assign cap_load = (sbe_hit || mbe_hit) && (det_q == '0);

  ecc_sbe_counter #(.THR_W(THR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hit(sbe_hit), .thr(thr_q),
    .fire(sbe_fire), .count(sbe_cnt)
  );

  ecc_capture_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load),
    .in_addr(ev_addr), .in_data(ev_data), .in_syn(ev_syn),
    .cap_addr(cap_addr), .cap_data(cap_data), .cap_syn(cap_syn)
  );

  ecc_inject_xor #(.DATA_W(DATA_W), .ECC_W(ECC_W), .WORD_W(REG_W)) u_inj (
    .enable(inj_ctl_q[INJ_EN_BIT]),
    .data_mask({inj_hi_q, inj_lo_q}),
    .ecc_mask(inj_ctl_q[ECC_W-1:0]),
    .in_data(wr_in_data), .in_ecc(wr_in_ecc),
    .out_data(wr_out_data), .out_ecc(wr_out_ecc)
  );

  assign wr_out_valid = wr_in_valid;
  assign wr_in_ready  = wr_out_ready;

  always_comb begin
    flg_set          = '0;
    flg_set[FLG_SBE] = sbe_fire;
    flg_set[FLG_MBE] = mbe_hit;
    flg_clr = (reg_wr && reg_addr == RI_DETECT) ? reg_wdata[FLG_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      det_q     <= '0;
      dis_q     <= '0;
      ien_q     <= '0;
      thr_q     <= '0;
      narrow_q  <= 1'b0;
      inj_hi_q  <= '0;
      inj_lo_q  <= '0;
      inj_ctl_q <= '0;
    end else begin
      det_q <= (det_q & ~flg_clr) | flg_set;
      if (reg_wr) begin
        case (reg_addr)
          RI_DISABLE: dis_q     <= reg_wdata[FLG_W-1:0];
          RI_INT_EN:  ien_q     <= reg_wdata[FLG_W-1:0];
          RI_SBE_CTL: thr_q     <= reg_wdata[THR_LSB +: THR_W];
          RI_CFG:     narrow_q  <= reg_wdata[0];
          RI_INJ_HI:  inj_hi_q  <= reg_wdata;
          RI_INJ_LO:  inj_lo_q  <= reg_wdata;
          RI_INJ_CTL: inj_ctl_q <= reg_wdata[CTL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign irq = |(det_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RI_DETECT:  reg_rdata = REG_W'(det_q);
      RI_DISABLE: reg_rdata = REG_W'(dis_q);
      RI_INT_EN:  reg_rdata = REG_W'(ien_q);
      RI_SBE_CTL: begin
        reg_rdata[THR_LSB +: THR_W] = thr_q;
        reg_rdata[THR_W-1:0]        = sbe_cnt;
      end
      RI_CFG:     reg_rdata = REG_W'(narrow_q);
      RI_CAP_ALO: reg_rdata = cap_addr[REG_W-1:0];
      RI_CAP_AHI: reg_rdata = REG_W'(cap_addr[ADDR_W-1:REG_W]);
      RI_CAP_DHI: reg_rdata = cap_data[DATA_W-1:REG_W];
      RI_CAP_DLO: reg_rdata = cap_data[REG_W-1:0];
      RI_CAP_SYN: reg_rdata = narrow_q ? REG_W'(cap_syn) : REG_W'(cap_syn[ECC_W-1:0]);
      RI_INJ_HI:  reg_rdata = inj_hi_q;
      RI_INJ_LO:  reg_rdata = inj_lo_q;
      RI_INJ_CTL: reg_rdata = REG_W'(inj_ctl_q);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
`timescale 1ns/1ps
module ecc_err_capture_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int THR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [1:0]        det,
  input logic [1:0]        dis,
  input logic [1:0]        ien,
  input logic [THR_W-1:0]  cnt,
  input logic [ADDR_W-1:0] cap_addr,
  input logic [DATA_W-1:0] cap_data,
  input logic              inj_en,
  input logic [DATA_W-1:0] in_data,
  input logic [ECC_W-1:0]  in_ecc,
  input logic [DATA_W-1:0] out_data,
  input logic [ECC_W-1:0]  out_ecc,
  input logic              irq
);
  // R2: multi-bit flag stays set unless software writes 1 to it
  a_r2_mbe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    det[1] && !(reg_wr && reg_addr == 4'd0 && reg_wdata[1]) |=> det[1]);

  // R3: capture registers frozen while any flag pending
  a_r3_capture_held: assert property (@(posedge clk) disable iff (!rst_n)
    (det != 2'b00) |=> ($stable(cap_addr) && $stable(cap_data)));

  // R4: correctable flag rises only as the counter wraps to zero
  a_r4_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det[0]) |-> (cnt == '0));

  // R5: a masked class cannot raise its flag
  a_r5_mbe_masked: assert property (@(posedge clk) disable iff (!rst_n)
    dis[1] && !det[1] |=> !det[1]);

  // R6: no interrupt while nothing is enabled
  a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);

  // R8: injection disarmed leaves the write stream untouched
  a_r8_inject_off: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_en |-> (out_data == in_data && out_ecc == in_ecc));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ECC_W(ECC_W), .THR_W(THR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .det(det_q), .dis(dis_q), .ien(ien_q),
  .cnt(sbe_cnt), .cap_addr(cap_addr), .cap_data(cap_data),
  .inj_en(inj_ctl_q[8]), .in_data(wr_in_data), .in_ecc(wr_in_ecc),
  .out_data(wr_out_data), .out_ecc(wr_out_ecc), .irq(irq)
);

// File: tb/sim_ecc_err_capture.sv
`timescale 1ns/1ps
module sim_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_valid = 1'b0, ev_sbe = 1'b0, ev_mbe = 1'b0;
  logic [39:0] ev_addr = '0;
  logic [63:0] ev_data = '0;
  logic [15:0] ev_syn = '0;
  logic        wr_in_valid = 1'b0, wr_in_ready, wr_out_valid, wr_out_ready = 1'b0;
  logic [63:0] wr_in_data = '0, wr_out_data;
  logic [7:0]  wr_in_ecc = '0, wr_out_ecc;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ecc_err_capture u0 (.*);

  // reference model state
  bit [1:0]  m_det, m_dis, m_ien;
  int        m_thr, m_cnt;
  bit        m_nar;
  bit [39:0] m_caddr;
  bit [63:0] m_cdata;
  bit [15:0] m_csyn;
  bit [31:0] m_ihi, m_ilo;
  bit [8:0]  m_ictl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_det = 0; m_dis = 0; m_ien = 0; m_thr = 0; m_cnt = 0; m_nar = 0;
      m_caddr = 0; m_cdata = 0; m_csyn = 0; m_ihi = 0; m_ilo = 0; m_ictl = 0;
    end else begin
      bit sh, mh, fire;
      bit [1:0] clr;
      int eff;
      sh = ev_valid && ev_sbe && !m_dis[0];
      mh = ev_valid && ev_mbe && !m_dis[1];
      if ((sh || mh) && m_det == 0) begin
        m_caddr = ev_addr; m_cdata = ev_data; m_csyn = ev_syn;
      end
      fire = 0;
      if (sh) begin
        eff = (m_thr == 0) ? 1 : m_thr;
        if (m_cnt + 1 >= eff) begin m_cnt = 0; fire = 1; end
        else m_cnt = m_cnt + 1;
      end
      clr = (reg_wr && reg_addr == 0) ? reg_wdata[1:0] : 2'b00;
      m_det = (m_det & ~clr) | {mh, fire};
      if (reg_wr) begin
        case (reg_addr)
          1:  m_dis = reg_wdata[1:0];
          2:  m_ien = reg_wdata[1:0];
          3:  m_thr = int'(reg_wdata[23:16]);
          4:  m_nar = reg_wdata[0];
          10: m_ihi = reg_wdata;
          11: m_ilo = reg_wdata;
          12: m_ictl = reg_wdata[8:0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit [31:0] mexp(input int a);
    case (a)
      0: return {30'd0, m_det};
      1: return {30'd0, m_dis};
      2: return {30'd0, m_ien};
      3: return (32'(m_thr) << 16) | 32'(m_cnt);
      4: return {31'd0, m_nar};
      5: return m_caddr[31:0];
      6: return {24'd0, m_caddr[39:32]};
      7: return m_cdata[63:32];
      8: return m_cdata[31:0];
      9: return m_nar ? {16'd0, m_csyn} : {24'd0, m_csyn[7:0]};
      10: return m_ihi;
      11: return m_ilo;
      12: return {23'd0, m_ictl};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison of irq and the write stream (R6, R8, R9)
  always @(posedge clk) begin
    #8;
    if (rst_n && !done) begin
      bit [63:0] ed;
      bit [7:0]  ee;
      ed = wr_in_data ^ (m_ictl[8] ? {m_ihi, m_ilo} : 64'd0);
      ee = wr_in_ecc ^ (m_ictl[8] ? m_ictl[7:0] : 8'd0);
      check("R6 irq", 64'(irq), 64'(|(m_det & m_ien)));
      check("R8 data", wr_out_data, ed);
      check("R8 ecc", 64'(wr_out_ecc), 64'(ee));
      check("R9 handshake", {62'd0, wr_out_valid, wr_in_ready}, {62'd0, wr_in_valid, wr_out_ready});
    end
  end

  always @(negedge clk) begin
    wr_in_data   <= {$urandom, $urandom};
    wr_in_ecc    <= 8'($urandom);
    wr_in_valid  <= 1'($urandom);
    wr_out_ready <= 1'($urandom);
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    reg_addr = 4'(a);
    #2;
    check(req, 64'(reg_rdata), 64'(mexp(a)));
  endtask

  task automatic ev(input bit s, input bit m, input logic [39:0] a, input logic [63:0] d, input logic [15:0] y);
    @(negedge clk);
    ev_valid = 1'b1; ev_sbe = s; ev_mbe = m; ev_addr = a; ev_data = d; ev_syn = y;
    @(negedge clk);
    ev_valid = 1'b0; ev_sbe = 1'b0; ev_mbe = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 13; i++) rd(i, "R1 reset");
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 regs", 64'(mexp(0)), 64'd0);

    // R2 R3 multi-bit capture
    ev(0, 1, 40'hA5_1234_5678, 64'hDEAD_BEEF_0123_4567, 16'h1234);
    rd(0, "R2 mbe flag");
    check("R2 mbe set", 64'(m_det), 64'd2);
    for (int i = 5; i < 10; i++) rd(i, "R3 capture");
    wr(2, 32'h3);
    check("R6 irq on", 64'(irq), 64'd1);
    ev(0, 1, 40'h11_0000_0000, 64'h1, 16'h00FF);
    rd(7, "R3 first held");
    rd(5, "R3 first held addr");
    // R2 write 0 keeps, write 1 clears
    wr(0, 32'h0);
    rd(0, "R2 write zero");
    wr(0, 32'h2);
    rd(0, "R2 w1c");
    check("R6 irq off", 64'(irq), 64'd0);

    // R4 threshold 0 acts as 1, then 0x00010000, then 3
    ev(1, 0, 40'h1, 64'h2, 16'h3);
    rd(0, "R4 thr0 flags");
    wr(0, 32'hFFFF_FFFF);
    rd(0, "R2 clear all");
    wr(3, 32'h0001_0000);
    ev(1, 0, 40'h5, 64'h6, 16'h7);
    rd(0, "R4 thr1");
    wr(0, 32'h1);
    wr(3, 32'h0003_0000);
    ev(1, 0, 40'h10, 64'h20, 16'h30);
    rd(3, "R4 count one");
    rd(5, "R3 recapture below threshold");
    ev(1, 0, 40'h11, 64'h21, 16'h31);
    rd(0, "R4 no flag at two");
    ev(1, 0, 40'h12, 64'h22, 16'h32);
    rd(0, "R4 flag at three");
    rd(3, "R4 count wrapped");

    // R5 disable
    wr(0, 32'h3);
    wr(1, 32'h3);
    ev(1, 1, 40'h77, 64'h88, 16'h99);
    rd(0, "R5 masked no flag");
    rd(3, "R5 masked no count");
    rd(5, "R5 masked no capture");
    wr(1, 32'h0);

    // R10 set and clear in same cycle
    @(negedge clk);
    ev_valid = 1'b1; ev_mbe = 1'b1; ev_addr = 40'h42; ev_data = 64'h43; ev_syn = 16'hABCD;
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h2;
    @(negedge clk);
    ev_valid = 1'b0; ev_mbe = 1'b0; reg_wr = 1'b0;
    rd(0, "R10 set wins");
    check("R10 model", 64'(m_det[1]), 64'd1);

    // R7 syndrome width
    rd(9, "R7 narrow off");
    wr(4, 32'h1);
    rd(9, "R7 narrow on");
    check("R7 value", 64'(reg_rdata), 64'h0000_ABCD);

    // R8 injection registers and stream
    wr(10, 32'hF0F0_0000);
    wr(11, 32'h0000_000F);
    wr(12, 32'h0000_00A5);
    repeat (4) @(negedge clk);
    wr(12, 32'h0000_01A5);
    for (int i = 10; i < 13; i++) rd(i, "R8 inject regs");
    repeat (8) @(negedge clk);
    wr(12, 32'h0);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule